// File: doc/BRIEF.md
# Fractional-Divide BCD Calendar Counter

This block keeps wall-clock time and calendar date in packed BCD registers. It is paced by a single-cycle enable that arrives at 4096 Hz. A fractional divider turns that enable into a 100 Hz step: it runs twenty-four periods of 41 enables followed by one period of 40. The average is 40.96 enables per step, so the step rate is exact every 1024 enables, which is every quarter second.

Each step advances a carry chain through hundredths, seconds, minutes, hours, day of week, date, month and year. Hours are held either as 00–23 or as 1–12 with an AM/PM flag. Months end on the correct date, February follows a divisible-by-four leap rule, and a century flag in the month register flips when the year wraps.

Software sets every register at once through a one-cycle parallel load. It reads the time through a snapshot request, which returns all eight fields copied in the same clock cycle.

Top module: `cal_core`

## Requirements
- R1: After a load, the first `tick_100` pulse follows the 41st accepted `tick_en`. Periods then repeat as twenty-four of 41 enables and one of 40, so exactly 25 steps occur in 1024 enables, and the next period is again 41.
- R2: On each step the hundredths advance through 00–99 BCD. Seconds and minutes advance through 00–59 BCD, each carrying into the next field when it wraps.
- R3: When hours bit 6 is 0, the hour is BCD 00–23 in bits 5:0. The step from 23:59:59.99 gives 00:00:00.00 and advances the day.
- R4: When hours bit 6 is 1, bits 4:0 hold BCD 1–12 and bit 5 is 1 for PM. Examples: 11 AM (0x51) steps to 12 PM (0x72), 12 PM (0x72) steps to 1 PM (0x61), and 11 PM (0x71) steps to 12 AM (0x52), which advances the day.
- R5: The day of week advances at midnight together with the date and wraps from 7 to 1.
- R6: In April, June, September and November the date 30 rolls over to 01 of the next month. In the other months the date 31 rolls over. Month 12 rolls over to month 01 and advances the year.
- R7: In February the last date is 29 when the BCD year is divisible by four, and 28 otherwise.
- R8: The month register holds BCD 01–12 in bits 4:0 and the century flag in bit 7. When the year wraps from 99 to 00, the century flag toggles.
- R9: A cycle with `ld_en` high writes all eight registers. It also restarts the divider at the start of a 41-enable period and discards any `tick_en` in that same cycle.
- R10: A cycle with `snap_req` high copies all eight live registers together. The copy appears on the `snap_*` outputs with `snap_vld` high on the next cycle.
- R11: After reset the time is 00:00:00.00 in 24-hour form, the day of week is 1, the date is 01, the month is 01 with the century flag 0, and the year is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle 4096 Hz pacing enable |
| ld_en | input | 1 | Parallel load strobe |
| ld_hund | input | 8 | Load value, hundredths (BCD) |
| ld_sec | input | 8 | Load value, seconds (BCD) |
| ld_min | input | 8 | Load value, minutes (BCD) |
| ld_hour | input | 8 | Load value, hours with mode and AM/PM bits |
| ld_dow | input | 8 | Load value, day of week 1–7 |
| ld_date | input | 8 | Load value, date (BCD) |
| ld_mon | input | 8 | Load value, month with century flag in bit 7 |
| ld_year | input | 8 | Load value, year (BCD) |
| snap_req | input | 1 | Snapshot request |
| snap_vld | output | 1 | Snapshot fields valid (one cycle) |
| snap_hund | output | 8 | Snapshot hundredths |
| snap_sec | output | 8 | Snapshot seconds |
| snap_min | output | 8 | Snapshot minutes |
| snap_hour | output | 8 | Snapshot hours |
| snap_dow | output | 8 | Snapshot day of week |
| snap_date | output | 8 | Snapshot date |
| snap_mon | output | 8 | Snapshot month and century flag |
| snap_year | output | 8 | Snapshot year |
| tick_100 | output | 1 | Registered 100 Hz step pulse |

## Verification
The range assertions on the hundredths and day-of-week registers hold only if every loaded value is legal BCD for its field, and the century check only pins toggles that are not caused by a load. The bench therefore loads only legal times and dates. It changes registers only through `ld_en`, and it raises `tick_en` for at most one cycle at a time, away from any load unless a test calls for that on purpose. Snapshots are requested only while `tick_en` is low, so each copy reflects a fully settled carry chain.

// File: rtl/cal_pkg.sv
package cal_pkg;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_year(input logic [7:0] y);
    logic [7:0] bin;
    bin = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
    leap_year = (bin[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_last(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h04, 5'h06, 5'h09, 5'h11: month_last = 8'h30;
      5'h02:                      month_last = leap_year(y) ? 8'h29 : 8'h28;
      default:                    month_last = 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_frac_div.sv
module cal_frac_div #(
  parameter int DIV_LONG  = 41,
  parameter int DIV_SHORT = 40,
  parameter int LONG_RUNS = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic en,
  output logic step
);
  localparam int CW = $clog2(DIV_LONG);
  localparam int PW = $clog2(LONG_RUNS + 1);
  localparam logic [CW-1:0] LAST_L = CW'(DIV_LONG - 1);
  localparam logic [CW-1:0] LAST_S = CW'(DIV_SHORT - 1);
  localparam logic [PW-1:0] PH_END = PW'(LONG_RUNS);

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] ph_q;
  logic [CW-1:0] last;

  always_comb last = (ph_q == PH_END) ? LAST_S : LAST_L;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
      ph_q  <= '0;
      step  <= 1'b0;
    end else begin
      step <= 1'b0;
      if (en) begin
        if (cnt_q == last) begin
          cnt_q <= '0;
          step  <= 1'b1;
          ph_q  <= (ph_q == PH_END) ? '0 : ph_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       ld_en,
  input  logic [7:0] ld_hund,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  output logic [7:0] hund,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic       day_roll
);
  logic       c_sec, c_min, c_hour;
  logic [7:0] hour_nx;
  logic       hour_wrap;
  logic [7:0] hinc;

  always_comb begin
    c_sec  = (hund == 8'h99);
    c_min  = c_sec && (sec == 8'h59);
    c_hour = c_min && (min == 8'h59);
    hour_nx   = hour;
    hour_wrap = 1'b0;
    hinc      = 8'h00;
    if (hour[6]) begin
      hinc = bcd_inc({3'b000, hour[4:0]});
      if (hour[4:0] == 5'h12) begin
        hour_nx = {2'b01, hour[5], 5'h01};
      end else if (hour[4:0] == 5'h11) begin
        hour_nx   = {2'b01, ~hour[5], 5'h12};
        hour_wrap = hour[5];
      end else begin
        hour_nx = {2'b01, hour[5], hinc[4:0]};
      end
    end else begin
      hinc = bcd_inc({2'b00, hour[5:0]});
      if (hour[5:0] == 6'h23) begin
        hour_nx   = 8'h00;
        hour_wrap = 1'b1;
      end else begin
        hour_nx = {2'b00, hinc[5:0]};
      end
    end
    day_roll = step && !ld_en && c_hour && hour_wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hund <= 8'h00;
      sec  <= 8'h00;
      min  <= 8'h00;
      hour <= 8'h00;
    end else if (ld_en) begin
      hund <= ld_hund;
      sec  <= ld_sec;
      min  <= ld_min;
      hour <= ld_hour;
    end else if (step) begin
      hund <= c_sec ? 8'h00 : bcd_inc(hund);
      if (c_sec)  sec  <= c_min  ? 8'h00 : bcd_inc(sec);
      if (c_min)  min  <= c_hour ? 8'h00 : bcd_inc(min);
      if (c_hour) hour <= hour_nx;
    end
  end
endmodule

// File: rtl/cal_calendar.sv
module cal_calendar
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       day_roll,
  input  logic       ld_en,
  input  logic [7:0] ld_dow,
  input  logic [7:0] ld_date,
  input  logic [7:0] ld_mon,
  input  logic [7:0] ld_year,
  output logic [7:0] dow,
  output logic [7:0] date,
  output logic [7:0] mon,
  output logic [7:0] year
);
  logic       m_end, y_end;
  logic [7:0] minc;

  always_comb begin
    m_end = (date == month_last(mon[4:0], year));
    y_end = m_end && (mon[4:0] == 5'h12);
    minc  = bcd_inc({3'b000, mon[4:0]});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dow  <= 8'h01;
      date <= 8'h01;
      mon  <= 8'h01;
      year <= 8'h00;
    end else if (ld_en) begin
      dow  <= ld_dow;
      date <= ld_date;
      mon  <= ld_mon & 8'h9F;
      year <= ld_year;
    end else if (day_roll) begin
      dow  <= (dow == 8'h07) ? 8'h01 : dow + 8'h01;
      date <= m_end ? 8'h01 : bcd_inc(date);
      if (m_end) begin
        if (y_end) begin
          mon  <= {(mon[7] ^ (year == 8'h99)), 2'b00, 5'h01};
          year <= (year == 8'h99) ? 8'h00 : bcd_inc(year);
        end else begin
          mon <= {mon[7], 2'b00, minc[4:0]};
        end
      end
    end
  end
endmodule

// File: rtl/cal_core.sv
module cal_core #(
  parameter int DIV_LONG  = 41,
  parameter int DIV_SHORT = 40,
  parameter int LONG_RUNS = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       ld_en,
  input  logic [7:0] ld_hund,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_dow,
  input  logic [7:0] ld_date,
  input  logic [7:0] ld_mon,
  input  logic [7:0] ld_year,
  input  logic       snap_req,
  output logic       snap_vld,
  output logic [7:0] snap_hund,
  output logic [7:0] snap_sec,
  output logic [7:0] snap_min,
  output logic [7:0] snap_hour,
  output logic [7:0] snap_dow,
  output logic [7:0] snap_date,
  output logic [7:0] snap_mon,
  output logic [7:0] snap_year,
  output logic       tick_100
);
  logic [7:0] cur_hund, cur_sec, cur_min, cur_hour;
  logic [7:0] cur_dow, cur_date, cur_mon, cur_year;
  logic       day_roll;

  cal_frac_div #(
    .DIV_LONG(DIV_LONG), .DIV_SHORT(DIV_SHORT), .LONG_RUNS(LONG_RUNS)
  ) u_div (
    .clk(clk), .rst(rst), .restart(ld_en), .en(tick_en), .step(tick_100)
  );

  cal_clock u_clk (
    .clk(clk), .rst(rst), .step(tick_100), .ld_en(ld_en),
    .ld_hund(ld_hund), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
    .hund(cur_hund), .sec(cur_sec), .min(cur_min), .hour(cur_hour),
    .day_roll(day_roll)
  );

  cal_calendar u_cal (
    .clk(clk), .rst(rst), .day_roll(day_roll), .ld_en(ld_en),
    .ld_dow(ld_dow), .ld_date(ld_date), .ld_mon(ld_mon), .ld_year(ld_year),
    .dow(cur_dow), .date(cur_date), .mon(cur_mon), .year(cur_year)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_vld  <= 1'b0;
      snap_hund <= 8'h00;
      snap_sec  <= 8'h00;
      snap_min  <= 8'h00;
      snap_hour <= 8'h00;
      snap_dow  <= 8'h00;
      snap_date <= 8'h00;
      snap_mon  <= 8'h00;
      snap_year <= 8'h00;
    end else begin
      snap_vld <= snap_req;
      if (snap_req) begin
        snap_hund <= cur_hund;
        snap_sec  <= cur_sec;
        snap_min  <= cur_min;
        snap_hour <= cur_hour;
        snap_dow  <= cur_dow;
        snap_date <= cur_date;
        snap_mon  <= cur_mon;
        snap_year <= cur_year;
      end
    end
  end
endmodule

// File: rtl/cal_core_chk.sv
module cal_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_en,
  input logic       ld_en,
  input logic       snap_req,
  input logic       snap_vld,
  input logic       tick_100,
  input logic [7:0] live_hund,
  input logic [7:0] live_dow,
  input logic [7:0] live_mon,
  input logic [7:0] live_year
);
  // R1, R9: a step follows an accepted enable that was not discarded by a load
  p_step_source_r1: assert property (@(posedge clk) disable iff (rst)
    tick_100 |-> ($past(tick_en) && !$past(ld_en)));

  // R9: the cycle after a load never carries a step
  p_load_holdoff_r9: assert property (@(posedge clk) disable iff (rst)
    $past(ld_en) |-> !tick_100);

  // R2: hundredths only move on a step or a load
  p_hund_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick_100 && !ld_en) |=> $stable(live_hund));

  // R2: hundredths stay legal BCD
  p_hund_range_r2: assert property (@(posedge clk) disable iff (rst)
    (live_hund[3:0] <= 4'd9) && (live_hund[7:4] <= 4'd9));

  // R5: day of week stays in 1..7
  p_dow_range_r5: assert property (@(posedge clk) disable iff (rst)
    (live_dow >= 8'h01) && (live_dow <= 8'h07));

  // R8: century flag changes only on a year wrap from 99
  p_century_r8: assert property (@(posedge clk) disable iff (rst)
    ((live_mon[7] != $past(live_mon[7])) && !$past(ld_en)) |-> ($past(live_year) == 8'h99));

  // R10: snapshot valid only answers a request
  p_snap_resp_r10: assert property (@(posedge clk) disable iff (rst)
    snap_vld |-> $past(snap_req));
endmodule

bind cal_core cal_core_chk u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .ld_en(ld_en),
  .snap_req(snap_req), .snap_vld(snap_vld), .tick_100(tick_100),
  .live_hund(cur_hund), .live_dow(cur_dow), .live_mon(cur_mon),
  .live_year(cur_year)
);

// File: tb/tb_cal_core.sv
module tb_cal_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0, ld_en = 1'b0, snap_req = 1'b0;
  logic [7:0] ld_hund = 0, ld_sec = 0, ld_min = 0, ld_hour = 0;
  logic [7:0] ld_dow = 0, ld_date = 0, ld_mon = 0, ld_year = 0;
  logic snap_vld, tick_100;
  logic [7:0] s_hund, s_sec, s_min, s_hour, s_dow, s_date, s_mon, s_year;

  int total = 0;
  int bad = 0;
  logic [63:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  cal_core dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .ld_en(ld_en),
    .ld_hund(ld_hund), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
    .ld_dow(ld_dow), .ld_date(ld_date), .ld_mon(ld_mon), .ld_year(ld_year),
    .snap_req(snap_req), .snap_vld(snap_vld),
    .snap_hund(s_hund), .snap_sec(s_sec), .snap_min(s_min), .snap_hour(s_hour),
    .snap_dow(s_dow), .snap_date(s_date), .snap_mon(s_mon), .snap_year(s_year),
    .tick_100(tick_100)
  );

  // monitor: pops the scoreboard on every snapshot
  always @(negedge clk) begin
    if (!rst && snap_vld) begin
      logic [63:0] got, exp;
      string tg;
      got = {s_hund, s_sec, s_min, s_hour, s_dow, s_date, s_mon, s_year};
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R10 unexpected snapshot actual=%h expected=none", got);
      end else begin
        exp = exp_q.pop_front();
        tg  = tag_q.pop_front();
        if (got !== exp) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", tg, got, exp);
        end
      end
    end
  end

  task automatic load(input logic [7:0] h, s, m, hr, dw, dt, mo, yr, input logic with_tick);
    ld_hund = h; ld_sec = s; ld_min = m; ld_hour = hr;
    ld_dow = dw; ld_date = dt; ld_mon = mo; ld_year = yr;
    ld_en = 1'b1; tick_en = with_tick;
    @(negedge clk);
    ld_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic snap(input logic [7:0] h, s, m, hr, dw, dt, mo, yr, input string tg);
    exp_q.push_back({h, s, m, hr, dw, dt, mo, yr});
    tag_q.push_back(tg);
    snap_req = 1'b1;
    @(negedge clk);
    snap_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    snap(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R11 reset");

    // R1 divider pattern
    load(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 1'b0);
    ticks(40);
    snap(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R1 40 enables");
    ticks(1);
    snap(8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R1 41 enables");
    ticks(982);
    snap(8'h24, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R1 1023 enables");
    ticks(1);
    snap(8'h25, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R1 1024 enables");
    ticks(40);
    snap(8'h25, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R1 next period long");
    ticks(1);
    snap(8'h26, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R1 next period end");

    // R9 load restarts divider and discards its own enable
    load(8'h50, 8'h10, 8'h20, 8'h05, 8'h03, 8'h15, 8'h06, 8'h10, 1'b0);
    ticks(40);
    load(8'h70, 8'h10, 8'h20, 8'h05, 8'h03, 8'h15, 8'h06, 8'h10, 1'b1);
    ticks(40);
    snap(8'h70, 8'h10, 8'h20, 8'h05, 8'h03, 8'h15, 8'h06, 8'h10, "R9 holdoff");
    ticks(1);
    snap(8'h71, 8'h10, 8'h20, 8'h05, 8'h03, 8'h15, 8'h06, 8'h10, "R9 first step");

    // R2 carry seconds to minutes
    load(8'h99, 8'h59, 8'h14, 8'h08, 8'h02, 8'h10, 8'h03, 8'h21, 1'b0);
    ticks(41);
    snap(8'h00, 8'h00, 8'h15, 8'h08, 8'h02, 8'h10, 8'h03, 8'h21, "R2 minute carry");

    // R3 24-hour 09 -> 10 and midnight; R5 dow wrap; R6 Dec end; R8 century
    load(8'h99, 8'h59, 8'h59, 8'h09, 8'h04, 8'h10, 8'h03, 8'h21, 1'b0);
    ticks(41);
    snap(8'h00, 8'h00, 8'h00, 8'h10, 8'h04, 8'h10, 8'h03, 8'h21, "R3 hour digit carry");
    load(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 1'b0);
    ticks(41);
    snap(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h81, 8'h00, "R8 R5 R3 year wrap");

    // R6 thirty-day month
    load(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h05, 1'b0);
    ticks(41);
    snap(8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h05, 8'h05, "R6 April end");

    // R7 leap and common February
    load(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h82, 8'h24, 1'b0);
    ticks(41);
    snap(8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h82, 8'h24, "R7 leap Feb 28");
    load(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 1'b0);
    ticks(41);
    snap(8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h23, "R7 common Feb 28");

    // R4 12-hour sequence
    load(8'h99, 8'h59, 8'h59, 8'h51, 8'h02, 8'h10, 8'h05, 8'h30, 1'b0);
    ticks(41);
    snap(8'h00, 8'h00, 8'h00, 8'h72, 8'h02, 8'h10, 8'h05, 8'h30, "R4 11AM to 12PM");
    load(8'h99, 8'h59, 8'h59, 8'h72, 8'h02, 8'h10, 8'h05, 8'h30, 1'b0);
    ticks(41);
    snap(8'h00, 8'h00, 8'h00, 8'h61, 8'h02, 8'h10, 8'h05, 8'h30, "R4 12PM to 1PM");
    load(8'h99, 8'h59, 8'h59, 8'h71, 8'h02, 8'h10, 8'h05, 8'h30, 1'b0);
    ticks(41);
    snap(8'h00, 8'h00, 8'h00, 8'h52, 8'h03, 8'h11, 8'h05, 8'h30, "R4 11PM to 12AM");

    // R10 snapshot holds while live time moves on
    ticks(41);
    snap(8'h01, 8'h00, 8'h00, 8'h52, 8'h03, 8'h11, 8'h05, 8'h30, "R10 fresh copy");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R10 missing snapshots actual=%0d expected=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule